// File: doc/BRIEF.md
# Incremental PID Controller Datapath

This block updates a discrete-time PID control signal once per sample strobe. It works in velocity form: it subtracts the feedback sample from the setpoint to get the current error, scales the current error and the two errors before it by three signed coefficients, and adds the three scaled products to the control value it produced last time. The coefficients are computed elsewhere from the gain, integral time, derivative time and sample period, and they arrive on ports. All three products and the sum are formed together, so one strobe produces one update.

The control output is an 8-bit unsigned actuator code. The sum is clamped to 0..255 and is never allowed to wrap. The clamped value, not the raw sum, is kept as the previous output, so the recurrence cannot wind up beyond the actuator limits. A result-valid pulse comes out one clock after each strobe. Between strobes the block holds its output and its error history.

Top module: `pid_incr_core`

## Requirements
- R1: A synchronous active-high reset clears the previous output, both stored past errors and the output-valid flag to zero.
- R2: The current error is the setpoint minus the feedback, both read as unsigned values, and it is formed as a signed value one bit wider than the samples.
- R3: On a strobe the new output is the previous output plus the three terms (b0·e[k]), (b1·e[k-1]) and (b2·e[k-2]). The coefficients are two's-complement with FRAC_W fractional bits, and each product is arithmetically shifted right by FRAC_W (it rounds toward minus infinity) before the sum.
- R4: The sum is clamped: a negative sum gives 0 and a sum above 255 gives 255. It never wraps.
- R5: The clamped value is stored as the previous output for the next update, so the recovery from a limit starts at the limit itself.
- R6: On each strobe the past errors shift: e[k-1] takes the current error and e[k-2] takes the old e[k-1].
- R7: ctrl_vld_o is high for exactly the one cycle after each strobe cycle, and ctrl_o carries the new result in that cycle.
- R8: While the strobe is low, ctrl_o and both stored errors keep their values, whatever happens on the setpoint and feedback inputs.
- R9: A strobe held high on consecutive cycles gives one complete update per cycle, with no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_vld_i | input | 1 | Sample strobe: perform one update in this cycle |
| setpoint_i | input | DATA_W | Setpoint sample, unsigned |
| feedback_i | input | DATA_W | Feedback sample, unsigned |
| coef_b0_i | input | COEF_W | Coefficient for e[k], signed fixed point |
| coef_b1_i | input | COEF_W | Coefficient for e[k-1], signed fixed point |
| coef_b2_i | input | COEF_W | Coefficient for e[k-2], signed fixed point |
| ctrl_o | output | DATA_W | Clamped control output, registered |
| ctrl_vld_o | output | 1 | One-cycle pulse marking a new ctrl_o |

## Verification
The assertions assume that the coefficient ports stay stable while the strobe is high and that the strobe is a clean 0/1 level, sampled only once reset has been released. The bench follows this: it changes the coefficients only inside a reset window, and it drives the strobe and the samples at the falling clock edge. The history and output hold checks depend on the strobe being low for whole cycles, so the bench holds the strobe low for several full cycles while it changes the samples.

// File: rtl/pid_incr_pkg.sv
package pid_incr_pkg;
  // number of error history taps (current, one back, two back)
  localparam int unsigned NUM_TAPS = 3;
  localparam int unsigned TAP_CUR  = 0;
  localparam int unsigned TAP_D1   = 1;
  localparam int unsigned TAP_D2   = 2;
endpackage

// File: rtl/pid_err_sub.sv
module pid_err_sub #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0]        setpoint,
  input  logic [DATA_W-1:0]        feedback,
  output logic signed [DATA_W:0]   err
);
  // zero-extend both samples, then take the signed difference
  assign err = $signed({1'b0, setpoint}) - $signed({1'b0, feedback});
endmodule

// File: rtl/pid_tap_mul.sv
module pid_tap_mul #(
  parameter int COEF_W = 16,
  parameter int ERR_W  = 9,
  parameter int FRAC_W = 8,
  localparam int PROD_W = COEF_W + ERR_W
) (
  input  logic signed [COEF_W-1:0] coef,
  input  logic signed [ERR_W-1:0]  err,
  output logic signed [PROD_W-1:0] scaled
);
  logic signed [PROD_W-1:0] coef_x;
  logic signed [PROD_W-1:0] err_x;
  logic signed [PROD_W-1:0] full;

  assign coef_x = PROD_W'(coef);
  assign err_x  = PROD_W'(err);
  assign full   = coef_x * err_x;
  // drop the fractional bits of the coefficient, keeping the sign
  assign scaled = full >>> FRAC_W;
endmodule

// File: rtl/pid_acc_sat.sv
module pid_acc_sat
  import pid_incr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PROD_W = 25
) (
  input  logic [DATA_W-1:0]        u_prev,
  input  logic signed [PROD_W-1:0] term [NUM_TAPS],
  output logic [DATA_W-1:0]        u_next
);
  localparam int GUARD = 3;
  localparam int SUM_W = PROD_W + GUARD;
  localparam logic signed [SUM_W-1:0] U_MAX = SUM_W'((1 << DATA_W) - 1);

  logic signed [SUM_W-1:0] acc;

  always_comb begin
    acc = $signed({{(SUM_W-DATA_W){1'b0}}, u_prev});
    for (int i = 0; i < int'(NUM_TAPS); i++) begin
      acc = acc + $signed({{GUARD{term[i][PROD_W-1]}}, term[i]});
    end
  end

  // clamp to the actuator code range
  always_comb begin
    if (acc < 0) begin
      u_next = '0;
    end else if (acc > U_MAX) begin
      u_next = '1;
    end else begin
      u_next = acc[DATA_W-1:0];
    end
  end
endmodule

// File: rtl/pid_incr_core.sv
module pid_incr_core
  import pid_incr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int COEF_W = 16,
  parameter int FRAC_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     sample_vld_i,
  input  logic [DATA_W-1:0]        setpoint_i,
  input  logic [DATA_W-1:0]        feedback_i,
  input  logic signed [COEF_W-1:0] coef_b0_i,
  input  logic signed [COEF_W-1:0] coef_b1_i,
  input  logic signed [COEF_W-1:0] coef_b2_i,
  output logic [DATA_W-1:0]        ctrl_o,
  output logic                     ctrl_vld_o
);
  localparam int ERR_W  = DATA_W + 1;
  localparam int PROD_W = COEF_W + ERR_W;

  logic signed [ERR_W-1:0]  err_now;
  logic signed [ERR_W-1:0]  err_d1_q;
  logic signed [ERR_W-1:0]  err_d2_q;
  logic [DATA_W-1:0]        u_prev_q;
  logic [DATA_W-1:0]        u_next;

  logic signed [COEF_W-1:0] coef_tap [NUM_TAPS];
  logic signed [ERR_W-1:0]  err_tap  [NUM_TAPS];
  logic signed [PROD_W-1:0] term_tap [NUM_TAPS];

  pid_err_sub #(.DATA_W(DATA_W)) u_err (
    .setpoint (setpoint_i),
    .feedback (feedback_i),
    .err      (err_now)
  );

  assign coef_tap[TAP_CUR] = coef_b0_i;
  assign coef_tap[TAP_D1]  = coef_b1_i;
  assign coef_tap[TAP_D2]  = coef_b2_i;
  assign err_tap[TAP_CUR]  = err_now;
  assign err_tap[TAP_D1]   = err_d1_q;
  assign err_tap[TAP_D2]   = err_d2_q;

  // one multiplier per tap, all active in the same cycle
  for (genvar t = 0; t < int'(NUM_TAPS); t++) begin : g_tap
    pid_tap_mul #(
      .COEF_W (COEF_W),
      .ERR_W  (ERR_W),
      .FRAC_W (FRAC_W)
    ) u_mul (
      .coef   (coef_tap[t]),
      .err    (err_tap[t]),
      .scaled (term_tap[t])
    );
  end

  pid_acc_sat #(
    .DATA_W (DATA_W),
    .PROD_W (PROD_W)
  ) u_acc (
    .u_prev (u_prev_q),
    .term   (term_tap),
    .u_next (u_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      u_prev_q <= '0;
      err_d1_q <= '0;
      err_d2_q <= '0;
    end else if (sample_vld_i) begin
      u_prev_q <= u_next;
      err_d1_q <= err_now;
      err_d2_q <= err_d1_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_vld_o <= 1'b0;
    end else begin
      ctrl_vld_o <= sample_vld_i;
    end
  end

  assign ctrl_o = u_prev_q;
endmodule

// File: rtl/pid_incr_chk.sv
module pid_incr_chk #(
  parameter int DATA_W = 8
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  vld_in,
  input logic                  vld_out,
  input logic [DATA_W-1:0]     ctrl,
  input logic signed [DATA_W:0] e_d1,
  input logic signed [DATA_W:0] e_d2
);
  logic rst_q = 1'b0;
  always_ff @(posedge clk) rst_q <= rst;

  always_ff @(posedge clk) begin
    if (rst_q && !rst) begin
      AST_RESET_CLEAR: assert (ctrl == '0 && !vld_out && e_d1 == '0 && e_d2 == '0); // R1
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    vld_in |=> vld_out); // R7
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
    !vld_in |=> !vld_out); // R7
  AST_IDLE_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !vld_in |=> $stable(ctrl)); // R8
  AST_IDLE_HIST_HOLD: assert property (@(posedge clk) disable iff (rst)
    !vld_in |=> ($stable(e_d1) && $stable(e_d2))); // R8
  AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (rst)
    vld_in |=> (e_d2 == $past(e_d1))); // R6
endmodule

bind pid_incr_core pid_incr_chk #(.DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .vld_in  (sample_vld_i),
  .vld_out (ctrl_vld_o),
  .ctrl    (ctrl_o),
  .e_d1    (err_d1_q),
  .e_d2    (err_d2_q)
);

// File: tb/pid_incr_core_test.sv
module pid_incr_core_test;
  localparam int DATA_W = 8;
  localparam int COEF_W = 16;
  localparam int FRAC_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic vld = 1'b0;
  logic [DATA_W-1:0] sp = '0;
  logic [DATA_W-1:0] fb = '0;
  logic signed [COEF_W-1:0] b0 = '0;
  logic signed [COEF_W-1:0] b1 = '0;
  logic signed [COEF_W-1:0] b2 = '0;
  logic [DATA_W-1:0] u_o;
  logic v_o;

  int n_chk = 0;
  int n_fail = 0;
  longint m_u, m_e1, m_e2;

  always #5 clk = ~clk;

  pid_incr_core #(.DATA_W(DATA_W), .COEF_W(COEF_W), .FRAC_W(FRAC_W)) uut (
    .clk (clk), .rst (rst), .sample_vld_i (vld),
    .setpoint_i (sp), .feedback_i (fb),
    .coef_b0_i (b0), .coef_b1_i (b1), .coef_b2_i (b2),
    .ctrl_o (u_o), .ctrl_vld_o (v_o)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference update, straight from the requirement text
  function automatic longint model_step(input int s, input int f);
    longint e, acc;
    e = longint'(s) - longint'(f);                                   // R2
    acc = m_u + ((longint'(b0) * e) >>> FRAC_W)
              + ((longint'(b1) * m_e1) >>> FRAC_W)
              + ((longint'(b2) * m_e2) >>> FRAC_W);                  // R3
    if (acc < 0) acc = 0;                                            // R4
    if (acc > 255) acc = 255;
    m_u = acc;                                                       // R5
    m_e2 = m_e1;                                                     // R6
    m_e1 = e;
    return acc;
  endfunction

  task automatic do_reset(input int c0, input int c1, input int c2);
    @(negedge clk);
    rst = 1'b1; vld = 1'b0;
    b0 = COEF_W'(c0); b1 = COEF_W'(c1); b2 = COEF_W'(c2);
    repeat (2) @(negedge clk);
    rst = 1'b0;
    m_u = 0; m_e1 = 0; m_e2 = 0;
    chk(u_o == 0, "R1 ctrl after reset", u_o, 0);
    chk(v_o == 1'b0, "R1 valid after reset", v_o, 0);
  endtask

  task automatic sample(input int s, input int f, input string req);
    longint exp;
    @(negedge clk);
    sp = DATA_W'(s); fb = DATA_W'(f); vld = 1'b1;
    exp = model_step(s, f);
    @(negedge clk);
    vld = 1'b0;
    chk(u_o == DATA_W'(exp), req, u_o, exp);
    chk(v_o == 1'b1, "R7 valid pulse", v_o, 1);
  endtask

  initial begin
    #1500000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    longint exp, held;
    // R2: pure current-error gain of 1.0
    do_reset(256, 0, 0);
    sample(100, 40, "R2 error sp-fb");
    do_reset(256, 0, 0);
    sample(40, 100, "R2 negative error clamps to 0");

    // R6: only the two-back tap is nonzero
    do_reset(0, 0, 256);
    sample(90, 40, "R6 tap2 step1");
    sample(40, 40, "R6 tap2 step2");
    sample(40, 40, "R6 tap2 step3 sees e[k-2]=50");
    chk(u_o == 50, "R6 e[k-2] value", u_o, 50);

    // R5: integrate to the top limit, then recover from it
    do_reset(256, 0, 0);
    for (int i = 0; i < 4; i++) sample(255, 0, "R4 upper clamp");
    chk(u_o == 255, "R4 held at 255", u_o, 255);
    sample(0, 10, "R5 recover from limit");
    chk(u_o == 245, "R5 no windup", u_o, 245);

    // R3 and R4: sweeps over several coefficient sets
    for (int set = 0; set < 5; set++) begin
      case (set)
        0: do_reset(256, -256, 0);
        1: do_reset(384, -200, 40);
        2: do_reset(-300, 100, 50);
        3: do_reset(1000, -1500, 600);
        default: do_reset(32767, -32768, 32767);
      endcase
      for (int s = 0; s < 256; s += 17) begin
        for (int f = 0; f < 256; f += 51) begin
          sample(s, f, "R3 sweep update");
        end
      end
      @(negedge clk);
      chk(v_o == 1'b0, "R7 valid is a single cycle", v_o, 0);
    end

    // R8: strobe low, inputs wiggle, nothing may move
    do_reset(300, -150, 80);
    sample(200, 20, "R3 pre-hold 1");
    sample(150, 90, "R3 pre-hold 2");
    held = longint'(u_o);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      sp = DATA_W'(i * 37); fb = DATA_W'(255 - i * 29);
      chk(u_o == DATA_W'(held), "R8 output hold", u_o, held);
      chk(v_o == 1'b0, "R8 no valid while idle", v_o, 0);
    end
    sample(120, 60, "R8 history unchanged after idle");

    // R9: strobe high on back-to-back cycles
    do_reset(384, -200, 40);
    exp = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (i > 0) begin
        chk(u_o == DATA_W'(exp), "R9 back-to-back update", u_o, exp);
        chk(v_o == 1'b1, "R9 valid each cycle", v_o, 1);
      end
      sp = DATA_W'((i * 53) % 256); fb = DATA_W'((i * 31 + 7) % 256); vld = 1'b1;
      exp = model_step((i * 53) % 256, (i * 31 + 7) % 256);
    end
    @(negedge clk);
    vld = 1'b0;
    chk(u_o == DATA_W'(exp), "R9 last back-to-back update", u_o, exp);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule